// File: doc/BRIEF.md
# Legacy FPU Error Interrupt Controller

This block turns the floating-point unit's error-summary flag into one legacy interrupt request line. It replaces the separate error and ignore pins an older design would have exposed. Software picks the reporting style with a numeric-error-mode control bit. When the bit is set, errors go to the core's own exception path and the interrupt line is held low. When it is clear, a pending FPU error raises the line.

The interrupt handler acknowledges the error with an I/O write of a single byte to port F0h or F1h. That write drops the request and tells the FPU to ignore numeric errors. The block leaves this ignore state by itself once the FPU lowers its error-summary flag, and then watches for errors again. Both outputs come from flip-flops, so they change only on a rising clock edge.

The I/O write port is a plain one-cycle strobe rather than a valid/ready stream. The block accepts every write in the cycle it is presented and never applies back-pressure.

Top module: `fpu_err_irq`

## Requirements
- R1: While `num_err_mode` is 1, `irq_o` is 0 one clock after every such cycle.
- R2: When `num_err_mode` is 0, `err_summary` is 1, the block is not ignoring and no acknowledge write is present, `irq_o` is 1 one clock later.
- R3: An acknowledge write forces `irq_o` to 0 one clock later. An acknowledge write is `io_wr_valid`=1 with `io_wr_size`=2'b00 (byte) and `io_wr_addr` equal to 16'h00F0 or 16'h00F1. If `err_summary` is 1 in that cycle, `ignore_o` is 1 one clock later.
- R4: When `err_summary` is 0 in a cycle, `ignore_o` is 0 one clock later and monitoring resumes.
- R5: A write to F0h or F1h with `io_wr_size`=2'b01 (16-bit) or 2'b10 (32-bit) leaves `irq_o` and `ignore_o` unchanged. So does a byte write to any other port.
- R6: While `ignore_o` is 1 and `err_summary` stays 1, `ignore_o` stays 1 and `irq_o` stays 0.
- R7: While `rst_n` is 0, `irq_o` and `ignore_o` are 0.
- R8: `irq_o` changes only at a rising edge of `clk`, never between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_err_mode | input | 1 | 1: errors reported natively, interrupt held low |
| err_summary | input | 1 | FPU error-summary flag |
| io_wr_valid | input | 1 | I/O write strobe, one cycle per write |
| io_wr_addr | input | 16 | I/O port address |
| io_wr_size | input | 2 | Operand size: 00 byte, 01 16-bit, 10 32-bit |
| irq_o | output | 1 | Interrupt request, active high |
| ignore_o | output | 1 | Tells the FPU to ignore numeric errors |

## Verification
On every cycle, the assertions check the one-cycle relations between the inputs and the outputs. These are: the mode bit masking the request, an error raising it, an acknowledge dropping it and entering ignore, a cleared flag leaving ignore, and the request never being high while ignoring. Three things are shown only by the bench's scenarios: that wrong-size or wrong-port writes change nothing, that the outputs read low during reset, and that the request does not move between edges. The bench also runs a long random stretch against its own behavioural model.

// File: rtl/fpu_err_irq_pkg.sv
package fpu_err_irq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10
  } io_size_e;

  typedef enum logic {
    ST_WATCH  = 1'b0,
    ST_IGNORE = 1'b1
  } err_state_e;
endpackage

// File: rtl/fpu_err_ack_decode.sv
module fpu_err_ack_decode #(
  parameter int ADDR_W    = 16,
  parameter int PORT_BASE = 'hF0,
  parameter int NUM_PORTS = 2
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  output logic              ack_hit
);
  import fpu_err_irq_pkg::*;

  logic [NUM_PORTS-1:0] port_match;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(PORT_BASE + g);
    assign port_match[g] = (wr_addr == PortAddr);
  end

  assign ack_hit = wr_valid && (wr_size == SZ_BYTE) && (|port_match);
endmodule

// File: rtl/fpu_err_state.sv
module fpu_err_state (
  input  logic clk,
  input  logic rst_n,
  input  logic num_err_mode,
  input  logic err_summary,
  input  logic ack_hit,
  output logic irq_q,
  output logic ignore_q
);
  import fpu_err_irq_pkg::*;

  err_state_e state_q, state_d;
  logic       irq_d;

  always_comb begin
    state_d = state_q;
    if (!err_summary)
      state_d = ST_WATCH;
    else if (ack_hit)
      state_d = ST_IGNORE;
    irq_d = !num_err_mode && err_summary && (state_d == ST_WATCH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WATCH;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign ignore_q = (state_q == ST_IGNORE);
endmodule

// File: rtl/fpu_err_irq.sv
module fpu_err_irq #(
  parameter int ADDR_W    = 16,
  parameter int PORT_BASE = 'hF0,
  parameter int NUM_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              num_err_mode,
  input  logic              err_summary,
  input  logic              io_wr_valid,
  input  logic [ADDR_W-1:0] io_wr_addr,
  input  logic [1:0]        io_wr_size,
  output logic              irq_o,
  output logic              ignore_o
);
  logic ack_hit;

  fpu_err_ack_decode #(
    .ADDR_W   (ADDR_W),
    .PORT_BASE(PORT_BASE),
    .NUM_PORTS(NUM_PORTS)
  ) u_decode (
    .wr_valid(io_wr_valid),
    .wr_addr (io_wr_addr),
    .wr_size (io_wr_size),
    .ack_hit (ack_hit)
  );

  fpu_err_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .num_err_mode(num_err_mode),
    .err_summary (err_summary),
    .ack_hit     (ack_hit),
    .irq_q       (irq_o),
    .ignore_q    (ignore_o)
  );
endmodule

// File: rtl/fpu_err_irq_chk.sv
module fpu_err_irq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              num_err_mode,
  input logic              err_summary,
  input logic              io_wr_valid,
  input logic [ADDR_W-1:0] io_wr_addr,
  input logic [1:0]        io_wr_size,
  input logic              irq_o,
  input logic              ignore_o
);
  logic ack_seen;
  assign ack_seen = io_wr_valid && io_wr_size == 2'b00 &&
                    (io_wr_addr == ADDR_W'('hF0) || io_wr_addr == ADDR_W'('hF1));

  p_mode_masks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    num_err_mode |=> !irq_o);

  p_error_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!num_err_mode && err_summary && !ignore_o && !ack_seen) |=> irq_o);

  p_ack_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> !irq_o);

  p_ack_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_seen && err_summary) |=> ignore_o);

  p_flag_low_resumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !err_summary |=> !ignore_o);

  p_ignore_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_o && err_summary) |=> (ignore_o && !irq_o));

  p_irq_excl_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !ignore_o);
endmodule

bind fpu_err_irq fpu_err_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_fpu_err_irq.sv
module test_fpu_err_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        num_err_mode = 1'b0;
  logic        err_summary = 1'b0;
  logic        io_wr_valid = 1'b0;
  logic [15:0] io_wr_addr = '0;
  logic [1:0]  io_wr_size = '0;
  logic        irq_o, ignore_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit m_irq, m_ign;

  always #10 clk = ~clk;

  fpu_err_irq i_fpu_err_irq (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: ignore persists while the flag is up, set by a byte ack.
  always @(posedge clk) begin
    bit ack, nxt_ign;
    ack = io_wr_valid && io_wr_size == 2'b00 &&
          (io_wr_addr == 16'h00F0 || io_wr_addr == 16'h00F1);
    if (!rst_n) begin
      m_irq <= 0; m_ign <= 0;
    end else begin
      nxt_ign = err_summary && (m_ign || ack);
      m_ign <= nxt_ign;
      m_irq <= !num_err_mode && err_summary && !nxt_ign;
    end
  end

  always @(negedge clk) if (model_on) begin
    chk("model irq R2", irq_o, m_irq);
    chk("model ignore R6", ignore_o, m_ign);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] s);
    io_wr_valid = 1; io_wr_addr = a; io_wr_size = s;
    step();
    io_wr_valid = 0;
  endtask

  initial begin
    step(2);
    chk("R7 irq in reset", irq_o, 0);
    chk("R7 ignore in reset", ignore_o, 0);
    rst_n = 1;
    step();
    model_on = 1;

    err_summary = 1; #5;
    chk("R8 irq before edge", irq_o, 0);
    step();
    chk("R2 raise", irq_o, 1);

    wr(16'h00F0, 2'b00);
    chk("R3 ack drops irq", irq_o, 0);
    chk("R3 ack sets ignore", ignore_o, 1);
    step(4);
    chk("R6 ignore held", ignore_o, 1);
    chk("R6 irq stays low", irq_o, 0);

    err_summary = 0; step();
    chk("R4 leave ignore", ignore_o, 0);
    err_summary = 1; step();
    chk("R2 re-raise", irq_o, 1);

    wr(16'h00F1, 2'b01);
    chk("R5 16-bit no effect irq", irq_o, 1);
    chk("R5 16-bit no effect ignore", ignore_o, 0);
    wr(16'h00F0, 2'b10);
    chk("R5 32-bit no effect", irq_o, 1);
    wr(16'h00F2, 2'b00);
    chk("R5 other port no effect", irq_o, 1);
    wr(16'h00F1, 2'b00);
    chk("R3 F1 ack", irq_o, 0);

    err_summary = 0; step();
    num_err_mode = 1; err_summary = 1; step(2);
    chk("R1 mode masks irq", irq_o, 0);
    num_err_mode = 0; step();
    chk("R2 unmask raises", irq_o, 1);

    for (int i = 0; i < 3000; i++) begin
      num_err_mode = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) err_summary = ~err_summary;
      io_wr_valid = ($urandom_range(0, 3) == 0);
      io_wr_addr  = 16'h00EF + 16'($urandom_range(0, 3));
      io_wr_size  = 2'($urandom_range(0, 2));
      step();
    end
    io_wr_valid = 0;
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule